// File: doc/BRIEF.md
# Display Panel Reset Pulse Sequencer

This block drives the active-low hardware reset line of an attached display panel. Software writes a timebase ratio and then a pulse descriptor with its start bit set. The block then drives a programmed number of low pulses onto the reset line and raises a sticky completion flag when the last pulse ends. Software clears the flag by writing 1 to a clear bit.

Pulse width is counted in coarse ticks of 2^ratio module clocks, not in raw clocks. The pulse repeats a programmable number of times, with a one-tick high gap between pulses, so delays longer than one width field can hold are still reachable. A second ratio field in the same timebase register drives an independent free-running tick output for neighbouring logic.

The interface is plain control: one write strobe, an address, a data word and three outputs. There is no data stream, so no valid/ready handshake applies.

Top module: `panel_reset_seq`

## Requirements
- R1: After reset, `panel_rst_n` is high and `seq_done` is low.
- R2: Each low pulse lasts exactly (W+1)·2^R clock cycles. W is the width field, bits [5:0] of the pulse register (address 1). R is the timer ratio latched at start.
- R3: A sequence emits exactly S+1 low pulses. S is the count field, SEQ_W bits wide starting at bit 8 of the pulse register.
- R4: Between two consecutive pulses, `panel_rst_n` is high for exactly 2^R clock cycles.
- R5: A write to address 1 with bit 16 set, while idle, starts a sequence. The prescaler restarts, and `panel_rst_n` is low from the clock edge that accepts the write.
- R6: `seq_done` rises on the same edge on which the final pulse ends. It then stays high until cleared.
- R7: A write to address 2 with bit 0 set clears `seq_done`. A write to address 2 with bit 0 clear has no effect. If completion and clear fall on the same edge, completion wins.
- R8: A start written while a sequence is running is ignored. The running waveform is unchanged.
- R9: Width, count and ratio are captured at start. A timebase write during a sequence does not change that sequence.
- R10: The timebase register (address 0) holds ratio0 in bits [3:0] and ratio1 in bits [7:4]. Their reset values are 15 and 9.
- R11: `aux_tick` is high for one cycle in every 2^ratio1 cycles. It is high in the (2^ratio1)-th cycle after the edge of a timebase write, which restarts it.
- R12: Writes to address 3 have no effect on the reset line or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| panel_rst_n | output | 1 | Active-low reset to the display panel, registered |
| seq_done | output | 1 | Sticky completion flag |
| aux_tick | output | 1 | Single-cycle tick every 2^ratio1 clocks |

## Verification
The bench builds the block with SEQ_W = 3 and every other parameter at its default. It first runs one sequence at the reset ratio of 15, which checks the longest tick, 32768 clocks. It then sweeps ratio0 over 0..2, width over 0..3 and count over 0..3, and predicts every cycle of the reset line and the flag from the pulse, gap and period arithmetic. Single runs at width 63 and count 7 reach the ends of both fields. Writes injected in the middle of a pulse and in a gap exercise the ignore and capture rules, and short windows after timebase writes test the auxiliary tick against its modulo count.

// File: rtl/prp_pkg.sv
package prp_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOW  = 2'd1,
    SQ_GAP  = 2'd2
  } seq_state_e;

  localparam int REG_TIMEBASE = 0;
  localparam int REG_PULSE    = 1;
  localparam int REG_CLEAR    = 2;

  localparam int PULSE_SEQ_LSB = 8;
  localparam int PULSE_GO_BIT  = 16;
  localparam int CLEAR_BIT     = 0;
endpackage

// File: rtl/prp_prescaler.sv
module prp_prescaler #(
  parameter int RATIO_W = 4,
  localparam int CNT_W  = (1 << RATIO_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wrap_mask;

  // A period of 2^ratio clocks ends when the low 'ratio' bits are all ones
  assign wrap_mask = ~({CNT_W{1'b1}} << ratio);
  assign tick      = (cnt_q == wrap_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (restart || tick)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/prp_regs.sv
module prp_regs
  import prp_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 32,
  parameter int RATIO_W    = 4,
  parameter int WIDTH_W    = 6,
  parameter int SEQ_W      = 6,
  parameter int RATIO0_RST = 15,
  parameter int RATIO1_RST = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [RATIO_W-1:0] ratio0,
  output logic [RATIO_W-1:0] ratio1,
  output logic               tb_write,
  output logic               go_req,
  output logic [WIDTH_W-1:0] go_width,
  output logic [SEQ_W-1:0]   go_count,
  output logic               clr_req
);
  logic hit_tb, hit_pulse, hit_clr;

  assign hit_tb    = wr_en && (wr_addr == ADDR_W'(REG_TIMEBASE));
  assign hit_pulse = wr_en && (wr_addr == ADDR_W'(REG_PULSE));
  assign hit_clr   = wr_en && (wr_addr == ADDR_W'(REG_CLEAR));

  assign tb_write = hit_tb;
  assign go_req   = hit_pulse && wr_data[PULSE_GO_BIT];
  assign go_width = wr_data[WIDTH_W-1:0];
  assign go_count = wr_data[PULSE_SEQ_LSB +: SEQ_W];
  assign clr_req  = hit_clr && wr_data[CLEAR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio0 <= RATIO_W'(RATIO0_RST);
      ratio1 <= RATIO_W'(RATIO1_RST);
    end else if (hit_tb) begin
      ratio0 <= wr_data[RATIO_W-1:0];
      ratio1 <= wr_data[2*RATIO_W-1:RATIO_W];
    end
  end
endmodule

// File: rtl/prp_sequencer.sv
module prp_sequencer
  import prp_pkg::*;
#(
  parameter int RATIO_W = 4,
  parameter int WIDTH_W = 6,
  parameter int SEQ_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_req,
  input  logic [WIDTH_W-1:0] go_width,
  input  logic [SEQ_W-1:0]   go_count,
  input  logic [RATIO_W-1:0] ratio_in,
  input  logic               clr_req,
  input  logic               tick,
  output logic [RATIO_W-1:0] run_ratio,
  output logic               accept,
  output logic               busy,
  output logic               line_n,
  output logic               done
);
  seq_state_e       state_q, state_d;
  logic [WIDTH_W-1:0] unit_q, unit_d;
  logic [SEQ_W-1:0]   pcnt_q, pcnt_d;
  logic [WIDTH_W-1:0] wid_q;
  logic [SEQ_W-1:0]   cnt_q;
  logic               last_unit, finish;

  assign accept    = go_req && (state_q == SQ_IDLE);
  assign busy      = (state_q != SQ_IDLE);
  assign last_unit = tick && (unit_q == wid_q);
  assign finish    = (state_q == SQ_LOW) && last_unit && (pcnt_q == cnt_q);

  always_comb begin
    state_d = state_q;
    unit_d  = unit_q;
    pcnt_d  = pcnt_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (go_req) begin
          state_d = SQ_LOW;
          unit_d  = '0;
          pcnt_d  = '0;
        end
      end
      SQ_LOW: begin
        if (last_unit) begin
          unit_d = '0;
          if (pcnt_q == cnt_q) begin
            state_d = SQ_IDLE;
          end else begin
            pcnt_d  = pcnt_q + 1'b1;
            state_d = SQ_GAP;
          end
        end else if (tick) begin
          unit_d = unit_q + 1'b1;
        end
      end
      SQ_GAP: begin
        if (tick) state_d = SQ_LOW;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      unit_q    <= '0;
      pcnt_q    <= '0;
      wid_q     <= '0;
      cnt_q     <= '0;
      run_ratio <= '0;
      line_n    <= 1'b1;
    end else begin
      state_q <= state_d;
      unit_q  <= unit_d;
      pcnt_q  <= pcnt_d;
      line_n  <= (state_d != SQ_LOW);
      if (accept) begin
        wid_q     <= go_width;
        cnt_q     <= go_count;
        run_ratio <= ratio_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      done <= 1'b0;
    else if (finish)
      done <= 1'b1;
    else if (clr_req)
      done <= 1'b0;
  end
endmodule

// File: rtl/panel_reset_seq.sv
module panel_reset_seq #(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 32,
  parameter int RATIO_W    = 4,
  parameter int WIDTH_W    = 6,
  parameter int SEQ_W      = 6,
  parameter int RATIO0_RST = 15,
  parameter int RATIO1_RST = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              panel_rst_n,
  output logic              seq_done,
  output logic              aux_tick
);
  logic [RATIO_W-1:0] ratio0, ratio1, run_ratio;
  logic               tb_write, go_req, clr_req, accept, busy, seq_tick;
  logic [WIDTH_W-1:0] go_width;
  logic [SEQ_W-1:0]   go_count;

  prp_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATIO_W(RATIO_W),
    .WIDTH_W(WIDTH_W), .SEQ_W(SEQ_W),
    .RATIO0_RST(RATIO0_RST), .RATIO1_RST(RATIO1_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ratio0(ratio0), .ratio1(ratio1),
    .tb_write(tb_write), .go_req(go_req), .go_width(go_width),
    .go_count(go_count), .clr_req(clr_req)
  );

  prp_prescaler #(.RATIO_W(RATIO_W)) u_seq_pre (
    .clk(clk), .rst_n(rst_n), .restart(accept),
    .ratio(run_ratio), .tick(seq_tick)
  );

  prp_prescaler #(.RATIO_W(RATIO_W)) u_aux_pre (
    .clk(clk), .rst_n(rst_n), .restart(tb_write),
    .ratio(ratio1), .tick(aux_tick)
  );

  prp_sequencer #(
    .RATIO_W(RATIO_W), .WIDTH_W(WIDTH_W), .SEQ_W(SEQ_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .go_req(go_req), .go_width(go_width),
    .go_count(go_count), .ratio_in(ratio0), .clr_req(clr_req),
    .tick(seq_tick), .run_ratio(run_ratio), .accept(accept),
    .busy(busy), .line_n(panel_rst_n), .done(seq_done)
  );
endmodule

// File: rtl/prp_checker.sv
module prp_checker #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              panel_rst_n,
  input logic              seq_done,
  input logic              busy
);
  logic clr_wr, go_wr, dead_wr;
  assign clr_wr  = wr_en && (wr_addr == ADDR_W'(2)) && wr_data[0];
  assign go_wr   = wr_en && (wr_addr == ADDR_W'(1)) && wr_data[16];
  assign dead_wr = wr_en && (wr_addr == ADDR_W'(3));

  AST_GO_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go_wr) |=> !panel_rst_n); // R5
  AST_LOW_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n |-> busy); // R3
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !clr_wr) |=> seq_done); // R6
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> $rose(panel_rst_n)); // R6
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !busy) |=> !seq_done); // R7
  AST_DEAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (dead_wr && !busy) |=> panel_rst_n); // R12
endmodule

bind panel_reset_seq prp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .panel_rst_n(panel_rst_n), .seq_done(seq_done),
  .busy(busy)
);

// File: tb/sim_panel_reset_seq.sv
`timescale 1ns/1ps
module sim_panel_reset_seq;
  localparam int SEQ_W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        panel_rst_n, seq_done, aux_tick;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  panel_reset_seq #(.SEQ_W(SEQ_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .panel_rst_n(panel_rst_n), .seq_done(seq_done),
    .aux_tick(aux_tick)
  );

  task automatic chk(input logic got, input logic exp, input string tag, input int k);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at k=%0d: got %b expected %b", tag, k, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  function automatic logic [31:0] pulse_word(input int w, input int s);
    return 32'(w) | (32'(s) << 8) | (32'd1 << 16);
  endfunction

  // inj: 0 none, 1 start write at inj_k, 2 timebase write at inj_k
  task automatic run_seq(input int r, input int w, input int s,
                         input int inj, input int inj_k, input string tag);
    int p, len, per, tend;
    p    = 1 << r;
    len  = p * (w + 1);
    per  = len + p;
    tend = (s + 1) * len + s * p;
    wr(2'd2, 32'd1);
    wr(2'd1, pulse_word(w, s));
    for (int k = 0; k <= tend + 3; k++) begin
      @(negedge clk);
      chk(panel_rst_n, !((k < tend) && ((k % per) < len)), tag, k);
      chk(seq_done, (k >= tend), {tag, "/R6"}, k);
      if (inj != 0 && k == inj_k) begin
        wr_en = 1'b1;
        wr_addr = (inj == 1) ? 2'd1 : 2'd0;
        wr_data = (inj == 1) ? pulse_word(0, 0) : (32'h90 | 32'(r + 1));
      end
      @(posedge clk);
      #1 wr_en = 1'b0;
    end
    if (inj == 2) wr(2'd0, 32'h90 | 32'(r));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(panel_rst_n, 1'b1, "R1 idle line", 0);
    chk(seq_done, 1'b0, "R1 flag", 0);

    // R10: ratio0 resets to 15, so one unit of width is 32768 clocks
    run_seq(15, 0, 0, 0, 0, "R10 reset ratio R2");

    // R2 R3 R4 R5: sweep over ratio, width and count
    for (int r = 0; r <= 2; r++) begin
      wr(2'd0, 32'h90 | 32'(r));
      for (int w = 0; w <= 3; w++)
        for (int s = 0; s <= 3; s++)
          run_seq(r, w, s, 0, 0, "R2/R3/R4/R5 sweep");
    end

    // Extremes of both fields
    wr(2'd0, 32'h90);
    run_seq(0, 63, 1, 0, 0, "R2 max width");
    run_seq(0, 0, 7, 0, 0, "R3 max count");

    // R8: start during a pulse and during a gap
    wr(2'd0, 32'h91);
    run_seq(1, 2, 2, 1, 1, "R8 start in pulse");
    run_seq(1, 2, 2, 1, 6, "R8 start in gap");
    // R9: timebase write during a run
    run_seq(1, 1, 2, 2, 2, "R9 ratio change");

    // R7: clear with bit0 low does nothing, bit0 high clears
    wr(2'd2, 32'hFFFF_FFFE);
    @(negedge clk);
    chk(seq_done, 1'b1, "R7 no-op clear", 0);
    wr(2'd2, 32'd1);
    @(negedge clk);
    chk(seq_done, 1'b0, "R7 clear", 0);

    // R12: dead address
    wr(2'd3, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(panel_rst_n, 1'b1, "R12 line", k);
      chk(seq_done, 1'b0, "R12 flag", k);
    end

    // R11: auxiliary tick
    wr(2'd0, 32'h20);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      chk(aux_tick, ((k + 1) % 4) == 0, "R11 ratio1=2", k);
    end
    wr(2'd0, 32'h00);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(aux_tick, 1'b1, "R11 ratio1=0", k);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule